// File: doc/BRIEF.md
# Reset Supervisor With Deglitched Faults

This block produces the system reset for a chip from four active-high fault flags: I/O supply low, core supply low, battery supply low and over-temperature. A fault must stay high for a set number of clock cycles before it is treated as real. While any qualified fault is present, the block pulls the shared reset line low. Once every fault has gone away, it keeps the line low for a further hold time and then lets go. The line is open-drain. The output `rst_line_n_o` is 0 when the block pulls the line down and 1 when it lets the line float.

The block also reads back the reset line through `line_sense_i`. When another device pulls the line low, the block takes over and runs a complete reset cycle of its own length. A line that has just been released may rise slowly. To keep that slow edge from starting a new cycle, the block ignores the sense input for a blanking window after each release.

All timing is counted in cycles of the free-running clock and set by parameters. The line-sense input and the fault inputs each pass through a two-flop synchronizer before any other logic sees them. A status output shows which fault sources were involved in the reset in progress, and a separate flag shows an external request. Both are cleared when the line is released.

Top module: `rsv_supervisor`

## Requirements
- R1: While `rst` is high, `rst_line_n_o` is 0, `cause_o` is 0 and `ext_cause_o` is 0. With no faults present, the line is released exactly HOLD_CYC clock edges after the first edge at which `rst` is low.
- R2: A fault input counts only after it has been high for FILT_CYC consecutive clock cycles. A pulse of FILT_CYC-1 cycles or fewer never pulls the line low.
- R3: The trigger is the OR of the four fault bits. A fault held high starting before edge k pulls the line low from edge k+FILT_CYC+2 onwards. The line then stays low for as long as any qualified fault is present.
- R4: After the last fault input falls (before edge k), the line is released at edge k+HOLD_CYC+2. The line is never released while a qualified fault is present.
- R5: If a qualified fault returns during the hold period, the hold restarts. Release then follows the timing of R4, counted from the fall of the returning fault.
- R6: If `line_sense_i` falls before edge k while the block is idle, the block pulls the line low from edge k+2 onwards. It sets `ext_cause_o` and holds the line low for HOLD_CYC edges from that point, whatever the line does in the meantime.
- R7: For BLANK_CYC cycles after each release, a low level on `line_sense_i` is ignored and the line stays released.
- R8: `cause_o` bit 0 is the I/O supply, bit 1 the core supply, bit 2 the battery supply and bit 3 over-temperature. It collects every fault that qualifies during the current reset. `cause_o` and `ext_cause_o` read 0 from the release edge onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 4 | Fault flags: [0] I/O low, [1] core low, [2] battery low, [3] over-temperature |
| line_sense_i | input | 1 | Level read back from the shared reset line |
| rst_line_n_o | output | 1 | 0 pulls the reset line low, 1 releases it |
| cause_o | output | 4 | Fault sources of the current reset, same bit order as `fault_i` |
| ext_cause_o | output | 1 | Current reset was requested from outside |

## Verification
The bench builds the block with FILT_CYC=4, HOLD_CYC=20 and BLANK_CYC=8. With these values the filter threshold can be probed on both sides, with a 3-cycle pulse and a sustained fault, and each release lands on an exact, countable edge. A 4-cycle pull right after a release lies wholly inside the blanking window even after the synchronizer delay. The hold period is also short enough to restart it partway through and still show that the line stays low past the point where the first release would have come.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int NUM_FLT = 4;

  localparam int FLT_IO   = 0;
  localparam int FLT_CORE = 1;
  localparam int FLT_BATT = 2;
  localparam int FLT_TEMP = 3;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_BLANK = 2'd1,
    ST_IDLE  = 2'd2
  } sup_state_e;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg <= {stg[STAGES-2:0], d};
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rsv_deglitch.sv
module rsv_deglitch #(
  parameter int FILT_CYC = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic s_i,
  output logic qual_o
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      qual_o  <= 1'b0;
    end else if (!s_i) begin
      run_cnt <= '0;
      qual_o  <= 1'b0;
    end else if (run_cnt == LAST) begin
      qual_o  <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
#(
  parameter int HOLD_CYC  = 50000,
  parameter int BLANK_CYC = 500,
  parameter int N         = NUM_FLT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] qual_i,
  input  logic         line_s_i,
  output logic         line_n_o,
  output logic [N-1:0] cause_o,
  output logic         ext_o,
  output logic         idle_o
);
  localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam int BW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST  = HW'(HOLD_CYC - 1);
  localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CYC - 1);

  sup_state_e    st;
  logic [HW-1:0] hold_cnt;
  logic [BW-1:0] blank_cnt;
  logic          any_q;
  logic          ext_req;

  assign any_q   = |qual_i;
  assign ext_req = !line_s_i;
  assign idle_o  = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_HOLD;
      hold_cnt  <= '0;
      blank_cnt <= '0;
      line_n_o  <= 1'b0;
      cause_o   <= '0;
      ext_o     <= 1'b0;
    end else begin
      unique case (st)
        ST_HOLD: begin
          cause_o <= cause_o | qual_i;
          if (any_q) begin
            hold_cnt <= '0;
          end else if (hold_cnt == HOLD_LAST) begin
            st        <= ST_BLANK;
            line_n_o  <= 1'b1;
            hold_cnt  <= '0;
            blank_cnt <= '0;
            cause_o   <= '0;
            ext_o     <= 1'b0;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        ST_BLANK: begin
          if (any_q) begin
            st       <= ST_HOLD;
            line_n_o <= 1'b0;
            hold_cnt <= '0;
            cause_o  <= qual_i;
            ext_o    <= 1'b0;
          end else if (blank_cnt == BLANK_LAST) begin
            st <= ST_IDLE;
          end else begin
            blank_cnt <= blank_cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (any_q || ext_req) begin
            st       <= ST_HOLD;
            line_n_o <= 1'b0;
            hold_cnt <= '0;
            cause_o  <= qual_i;
            ext_o    <= ext_req;
          end
        end
        default: begin
          st       <= ST_HOLD;
          line_n_o <= 1'b0;
          hold_cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rsv_supervisor.sv
module rsv_supervisor
  import rsv_pkg::*;
#(
  parameter int FILT_CYC    = 150,
  parameter int HOLD_CYC    = 50000,
  parameter int BLANK_CYC   = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_FLT-1:0] fault_i,
  input  logic               line_sense_i,
  output logic               rst_line_n_o,
  output logic [NUM_FLT-1:0] cause_o,
  output logic               ext_cause_o
);
  localparam int SW = NUM_FLT + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {NUM_FLT{1'b0}}};

  logic [SW-1:0]      sync_q;
  logic [NUM_FLT-1:0] fault_s;
  logic               line_s;
  logic [NUM_FLT-1:0] qual;
  logic               ctrl_idle;

  rsv_sync #(
    .W       (SW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({line_sense_i, fault_i}),
    .q   (sync_q)
  );

  assign fault_s = sync_q[NUM_FLT-1:0];
  assign line_s  = sync_q[NUM_FLT];

  generate
    for (genvar i = 0; i < NUM_FLT; i++) begin : g_flt
      rsv_deglitch #(
        .FILT_CYC (FILT_CYC)
      ) u_dg (
        .clk    (clk),
        .rst    (rst),
        .s_i    (fault_s[i]),
        .qual_o (qual[i])
      );
    end
  endgenerate

  rsv_ctrl #(
    .HOLD_CYC  (HOLD_CYC),
    .BLANK_CYC (BLANK_CYC),
    .N         (NUM_FLT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .qual_i   (qual),
    .line_s_i (line_s),
    .line_n_o (rst_line_n_o),
    .cause_o  (cause_o),
    .ext_o    (ext_cause_o),
    .idle_o   (ctrl_idle)
  );
endmodule

// File: rtl/rsv_supervisor_chk.sv
module rsv_supervisor_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         line_n,
  input logic [N-1:0] cause,
  input logic         ext,
  input logic [N-1:0] qual,
  input logic [N-1:0] fsync,
  input logic         line_s,
  input logic         idle
);
  p_qual_pulls_low_r3: assert property (@(posedge clk) disable iff (rst)
    (|qual) |=> !line_n);

  p_release_clean_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(line_n) |-> ($past(qual) == '0));

  p_status_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(line_n) |-> (cause == '0 && !ext));

  p_status_only_low_r8: assert property (@(posedge clk) disable iff (rst)
    ((cause != '0) || ext) |-> !line_n);

  p_ext_fast_r6: assert property (@(posedge clk) disable iff (rst)
    (idle && !line_s) |=> (!line_n && ext));

  p_blank_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (line_n && !idle && (qual == '0)) |=> line_n);

  generate
    for (genvar i = 0; i < N; i++) begin : g_f
      p_qual_needs_input_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(qual[i]) |-> $past(fsync[i]));
    end
  endgenerate
endmodule

bind rsv_supervisor rsv_supervisor_chk #(.N(rsv_pkg::NUM_FLT)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .line_n (rst_line_n_o),
  .cause  (cause_o),
  .ext    (ext_cause_o),
  .qual   (qual),
  .fsync  (fault_s),
  .line_s (line_s),
  .idle   (ctrl_idle)
);

// File: tb/rsv_supervisor_tb.sv
`timescale 1ns/1ps
module rsv_supervisor_tb;
  localparam int FILT  = 4;
  localparam int HOLD  = 20;
  localparam int BLANK = 8;

  typedef struct {
    string      req;
    logic       exp_n;
    logic [3:0] exp_cause;
    logic       exp_ext;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] fault = 4'b0;
  logic       ext_pull = 1'b0;
  logic       line_sense;
  logic       rst_line_n;
  logic [3:0] cause;
  logic       ext_cause;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  assign line_sense = rst_line_n & ~ext_pull;

  always #10 clk = ~clk;

  rsv_supervisor #(
    .FILT_CYC  (FILT),
    .HOLD_CYC  (HOLD),
    .BLANK_CYC (BLANK)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .fault_i      (fault),
    .line_sense_i (line_sense),
    .rst_line_n_o (rst_line_n),
    .cause_o      (cause),
    .ext_cause_o  (ext_cause)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic n,
                            input logic [3:0] c, input logic e);
    exp_t it;
    it.req = req; it.exp_n = n; it.exp_cause = c; it.exp_ext = e;
    sb.push_back(it);
  endtask

  // monitor: pops expected items shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        total++;
        if (rst_line_n !== it.exp_n || cause !== it.exp_cause || ext_cause !== it.exp_ext) begin
          bad++;
          $display("FAIL %s actual line_n=%0b cause=%b ext=%0b expected line_n=%0b cause=%b ext=%0b",
                   it.req, rst_line_n, cause, ext_cause, it.exp_n, it.exp_cause, it.exp_ext);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then release after HOLD edges
    step(3);
    expect_out("R1 in reset", 1'b0, 4'b0, 1'b0);
    rst = 1'b0;
    step(HOLD - 1);
    expect_out("R1 still held", 1'b0, 4'b0, 1'b0);
    step(1);
    expect_out("R1 released", 1'b1, 4'b0, 1'b0);
    step(12);

    // R2: short pulse ignored
    fault = 4'b0001;
    step(FILT - 1);
    fault = 4'b0000;
    step(10);
    expect_out("R2 short pulse ignored", 1'b1, 4'b0, 1'b0);

    // R3: sustained battery fault, exact assertion edge
    fault = 4'b0100;
    step(FILT + 2);
    expect_out("R3 before qualify", 1'b1, 4'b0, 1'b0);
    step(1);
    expect_out("R3 asserted, R8 battery bit", 1'b0, 4'b0100, 1'b0);
    step(5);
    expect_out("R3 held during fault", 1'b0, 4'b0100, 1'b0);

    // R4: hold after clear, R8 cleared
    fault = 4'b0000;
    step(HOLD + 2);
    expect_out("R4 hold not done", 1'b0, 4'b0100, 1'b0);
    step(1);
    expect_out("R4 released, R8 cleared", 1'b1, 4'b0, 1'b0);
    step(12);

    // R5: retrigger during hold
    fault = 4'b0001;
    step(FILT + 3);
    expect_out("R5 first assert", 1'b0, 4'b0001, 1'b0);
    fault = 4'b0000;
    step(10);
    fault = 4'b0001;
    step(8);
    fault = 4'b0000;
    step(HOLD + 2);
    expect_out("R5 hold restarted", 1'b0, 4'b0001, 1'b0);
    step(1);
    expect_out("R5 released after restart", 1'b1, 4'b0, 1'b0);
    step(12);

    // R8: two sources recorded together
    fault = 4'b1010;
    step(FILT + 3);
    expect_out("R8 core and temp bits", 1'b0, 4'b1010, 1'b0);
    fault = 4'b0000;
    step(HOLD + 3);
    expect_out("R8 cleared on release", 1'b1, 4'b0, 1'b0);
    step(12);

    // R6: external pull
    ext_pull = 1'b1;
    step(2);
    expect_out("R6 not yet driven", 1'b1, 4'b0, 1'b0);
    step(1);
    expect_out("R6 driven within bound", 1'b0, 4'b0, 1'b1);
    ext_pull = 1'b0;
    step(HOLD - 1);
    expect_out("R6 full hold", 1'b0, 4'b0, 1'b1);
    step(1);
    expect_out("R6 released", 1'b1, 4'b0, 1'b0);

    // R7: slow rise right after release is blanked
    ext_pull = 1'b1;
    step(4);
    ext_pull = 1'b0;
    step(10);
    expect_out("R7 blanked low ignored", 1'b1, 4'b0, 1'b0);

    // R6 again: after blanking the line is watched
    ext_pull = 1'b1;
    step(3);
    expect_out("R6 watched after blank", 1'b0, 4'b0, 1'b1);
    ext_pull = 1'b0;
    step(HOLD + 2);
    expect_out("R6 second release", 1'b1, 4'b0, 1'b0);

    step(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule